// File: doc/BRIEF.md
# Output-Stationary Systolic Matrix Multiplier

This block multiplies two square matrices of signed integers on a grid of identical multiply-accumulate cells. Each cell is wired only to its nearest neighbours, and every cell updates on the same clock edge. The right-hand operand enters along the top edge and moves one cell down per cycle. The left-hand operand enters along the left edge and moves one cell right per cycle. Each cell multiplies the pair of words passing through it and adds the product into a sum that it keeps locally. The result matrix therefore builds up in place, one element per cell.

The caller pulses `start_i` and then, over the next N cycles, presents one column of A and one row of B per cycle. The block delays each edge lane so that matching index pairs meet in the right cell. Once the real words run out it feeds zeros, until every cell has combined a full row with a full column, which takes 3N-2 cycles. The sums then shift down their columns and leave through the bottom edge, one result row per cycle with the last row first. A one-cycle `done_o` pulse closes the run.

Top module: `sysmm_top`

## Requirements
- R1: While reset is applied and in the first cycle after it is released, `res_valid_o` and `done_o` are 0 and every lane of `res_o` is 0.
- R2: Each drained result element C[i][j] equals the sum over k of A[i][k]*B[k][j], computed as a two's-complement signed value that is ACC_W bits wide.
- R3: Number the clock edge that samples an accepted start as cycle 0. `res_valid_o` is then high in cycles 3N-2 through 4N-3 inclusive and low in every other cycle of the run.
- R4: In valid cycle 3N-2+d, `res_o` carries result row N-1-d. Result column j sits at bits [j*ACC_W +: ACC_W].
- R5: In cycle k of the run, for k = 0..N-1, the left port lane i (bits [i*DATA_W +: DATA_W]) must hold A[i][k], and the top port lane j must hold B[k][j]. Values on the operand ports in any other cycle have no effect on the results.
- R6: `done_o` is high only in cycle 4N-2, for exactly one cycle, and never in the same cycle as `res_valid_o`.
- R7: A start pulse that arrives in cycles 0 through 4N-2 of a run is ignored. The run keeps its timing and its results.
- R8: The extreme operands (every entry -128, every entry 127, or A at -128 with B at 127) give exact products with no wrap-around.
- R9: A start accepted after a finished run clears every sum and every in-flight operand. Each run's results depend only on its own operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only when idle |
| a_left_i | input | N*DATA_W | One column of A, lane i = row i |
| b_top_i | input | N*DATA_W | One row of B, lane j = column j |
| res_o | output | N*ACC_W | One result row, lane j = column j |
| res_valid_o | output | 1 | res_o holds a result row |
| done_o | output | 1 | One-cycle pulse at the end of a run |

## Verification
The assertions assume three things about the inputs. Operands arrive in the N cycles after the start edge. A start may be raised at any time, because starts are filtered by the idle check. Operand values outside the feed window are arbitrary. The stimulus keeps to these assumptions and drives random garbage on the operand ports outside the window, so that any leak of those values would show up as a wrong result. One run also raises start in the middle of computation, and the assertion on ignored starts, together with the exact valid window, exposes any restart. Back-to-back runs with unrelated matrices check that the hold assertion and the clear on start leave no sum behind from an earlier run.

// File: rtl/sysmm_pkg.sv
package sysmm_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_COMP  = 2'd1,
    PH_DRAIN = 2'd2,
    PH_FIN   = 2'd3
  } phase_e;

  // Signed multiply-accumulate, product sign-extended to the sum width.
  function automatic logic signed [23:0] mac_step(
    input logic signed [23:0] acc,
    input logic signed [7:0]  a,
    input logic signed [7:0]  b
  );
    logic signed [15:0] p;
    p = a * b;
    return acc + {{8{p[15]}}, p};
  endfunction

endpackage

// File: rtl/sysmm_ctrl.sv
module sysmm_ctrl
  import sysmm_pkg::*;
#(
  parameter int N = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic clr_o,
  output logic feed_o,
  output logic mac_o,
  output logic shift_o,
  output logic valid_o,
  output logic done_o
);
  localparam int COMP_LEN = 3 * N - 2;
  localparam int CW = $clog2(3 * N + 1);

  phase_e ph_q;
  logic [CW-1:0] cnt_q;
  logic accept;
  logic comp_last, drain_last;

  assign accept     = start_i && (ph_q == PH_IDLE);
  assign comp_last  = (ph_q == PH_COMP)  && (cnt_q == CW'(COMP_LEN - 1));
  assign drain_last = (ph_q == PH_DRAIN) && (cnt_q == CW'(N - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: begin
          if (accept) begin
            ph_q  <= PH_COMP;
            cnt_q <= '0;
          end
        end
        PH_COMP: begin
          if (comp_last) begin
            ph_q  <= PH_DRAIN;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_DRAIN: begin
          if (drain_last) begin
            ph_q  <= PH_FIN;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign clr_o   = accept;
  assign mac_o   = (ph_q == PH_COMP);
  assign feed_o  = (ph_q == PH_COMP) && (cnt_q < CW'(N));
  assign shift_o = (ph_q == PH_DRAIN);
  assign valid_o = (ph_q == PH_DRAIN);
  assign done_o  = (ph_q == PH_FIN);

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PH_IDLE && start_i) |=> !(ph_q == PH_COMP && cnt_q == '0)); // R7

  AST_DRAIN_FOLLOWS_COMP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> ($past(ph_q) == PH_COMP && $past(cnt_q) == CW'(COMP_LEN - 1))); // R3

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R6

  AST_DONE_NOT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && valid_o)); // R6

  AST_DONE_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(valid_o)); // R6

endmodule

// File: rtl/sysmm_skew.sv
module sysmm_skew #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr_i,
  input  logic                     en_i,
  input  logic signed [DATA_W-1:0] d_i,
  output logic signed [DATA_W-1:0] q_o
);
  generate
    if (DEPTH == 0) begin : g_pass
      assign q_o = d_i;
    end else begin : g_line
      logic signed [DATA_W-1:0] stg_q [DEPTH];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int s = 0; s < DEPTH; s++) stg_q[s] <= '0;
        end else if (clr_i) begin
          for (int s = 0; s < DEPTH; s++) stg_q[s] <= '0;
        end else if (en_i) begin
          stg_q[0] <= d_i;
          for (int s = 1; s < DEPTH; s++) stg_q[s] <= stg_q[s-1];
        end
      end
      assign q_o = stg_q[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/sysmm_cell.sv
module sysmm_cell
  import sysmm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr_i,
  input  logic                     mac_i,
  input  logic                     shift_i,
  input  logic signed [DATA_W-1:0] a_i,
  input  logic signed [DATA_W-1:0] b_i,
  input  logic signed [ACC_W-1:0]  acc_up_i,
  output logic signed [DATA_W-1:0] a_o,
  output logic signed [DATA_W-1:0] b_o,
  output logic signed [ACC_W-1:0]  acc_o
);
  logic signed [ACC_W-1:0] acc_next;
  assign acc_next = mac_step(acc_o, a_i, b_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_o   <= '0;
      b_o   <= '0;
      acc_o <= '0;
    end else if (clr_i) begin
      a_o   <= '0;
      b_o   <= '0;
      acc_o <= '0;
    end else if (mac_i) begin
      a_o   <= a_i;
      b_o   <= b_i;
      acc_o <= acc_next;
    end else if (shift_i) begin
      acc_o <= acc_up_i;
    end
  end

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !mac_i && !shift_i) |=> $stable(acc_o)); // R9

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (acc_o == '0)); // R9

endmodule

// File: rtl/sysmm_top.sv
module sysmm_top #(
  parameter int N      = 4,
  parameter int DATA_W = 8,
  parameter int ACC_W  = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [N*DATA_W-1:0] a_left_i,
  input  logic [N*DATA_W-1:0] b_top_i,
  output logic [N*ACC_W-1:0]  res_o,
  output logic                res_valid_o,
  output logic                done_o
);
  logic clr, feed, mac, shift;

  logic signed [DATA_W-1:0] a_lnk [N][N+1];
  logic signed [DATA_W-1:0] b_lnk [N+1][N];
  logic signed [ACC_W-1:0]  acc_q [N][N];
  logic signed [ACC_W-1:0]  acc_up [N][N];

  sysmm_ctrl #(.N(N)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .clr_o(clr), .feed_o(feed), .mac_o(mac), .shift_o(shift),
    .valid_o(res_valid_o), .done_o(done_o)
  );

  genvar gi, gj;
  generate
    for (gi = 0; gi < N; gi++) begin : g_edge
      logic signed [DATA_W-1:0] a_gated, b_gated;
      assign a_gated = feed ? a_left_i[gi*DATA_W +: DATA_W] : '0;
      assign b_gated = feed ? b_top_i[gi*DATA_W +: DATA_W]  : '0;

      sysmm_skew #(.DATA_W(DATA_W), .DEPTH(gi)) skew_a_i (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .en_i(mac),
        .d_i(a_gated), .q_o(a_lnk[gi][0])
      );
      sysmm_skew #(.DATA_W(DATA_W), .DEPTH(gi)) skew_b_i (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .en_i(mac),
        .d_i(b_gated), .q_o(b_lnk[0][gi])
      );
      assign res_o[gi*ACC_W +: ACC_W] = acc_q[N-1][gi];
    end

    for (gi = 0; gi < N; gi++) begin : g_row
      for (gj = 0; gj < N; gj++) begin : g_col
        if (gi == 0) begin : g_top
          assign acc_up[gi][gj] = '0;
        end else begin : g_inner
          assign acc_up[gi][gj] = acc_q[gi-1][gj];
        end
        sysmm_cell #(.DATA_W(DATA_W), .ACC_W(ACC_W)) cell_i (
          .clk(clk), .rst_n(rst_n), .clr_i(clr), .mac_i(mac), .shift_i(shift),
          .a_i(a_lnk[gi][gj]), .b_i(b_lnk[gi][gj]), .acc_up_i(acc_up[gi][gj]),
          .a_o(a_lnk[gi][gj+1]), .b_o(b_lnk[gi+1][gj]), .acc_o(acc_q[gi][gj])
        );
      end
    end
  endgenerate

  AST_RESULT_ONLY_WHEN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (res_o == '0)); // R4

  AST_NO_FEED_IN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |-> !feed); // R5

endmodule

// File: tb/sysmm_top_tb_top.sv
`timescale 1ns/1ps
module sysmm_top_tb_top;
  localparam int N = 4;
  localparam int DW = 8;
  localparam int AW = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [N*DW-1:0] a_left_i = '0;
  logic [N*DW-1:0] b_top_i = '0;
  logic [N*AW-1:0] res_o;
  logic res_valid_o, done_o;

  int n_chk = 0;
  int n_bad = 0;

  logic signed [DW-1:0] ma [N][N];
  logic signed [DW-1:0] mb [N][N];

  always #10 clk = ~clk;

  sysmm_top #(.N(N), .DATA_W(DW), .ACC_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .a_left_i(a_left_i), .b_top_i(b_top_i),
    .res_o(res_o), .res_valid_o(res_valid_o), .done_o(done_o)
  );

  function automatic int ref_elem(int i, int j);
    int s = 0;
    for (int k = 0; k < N; k++) s += int'(ma[i][k]) * int'(mb[k][j]);
    return s;
  endfunction

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run(input bit inject, input string req);
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    for (int c = 0; c <= 4 * N - 1; c++) begin
      for (int l = 0; l < N; l++) begin
        if (c < N) begin
          a_left_i[l*DW +: DW] = ma[l][c];
          b_top_i[l*DW +: DW]  = mb[c][l];
        end else begin
          a_left_i[l*DW +: DW] = DW'($urandom);
          b_top_i[l*DW +: DW]  = DW'($urandom);
        end
      end
      start_i = inject && (c == 2 || c == 4 * N - 2);
      // R3 valid window, R6 done pulse
      check("R3", res_valid_o, (c >= 3 * N - 2 && c <= 4 * N - 3));
      check("R6", done_o, (c == 4 * N - 2));
      if (res_valid_o) begin
        for (int j = 0; j < N; j++) begin
          // R2/R4 row order last-first, R5 garbage ignored
          check(req, longint'($signed(res_o[j*AW +: AW])),
                longint'(ref_elem(N - 1 - (c - (3 * N - 2)), j)));
        end
      end
      @(negedge clk);
    end
    start_i = 1'b0;
  endtask

  task automatic fill_rand(input bit neg_only);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        ma[i][j] = DW'($urandom);
        mb[i][j] = DW'($urandom);
        if (neg_only) begin
          ma[i][j][DW-1] = 1'b1;
          mb[i][j][DW-1] = 1'b1;
        end
      end
  endtask

  task automatic fill_const(input logic signed [DW-1:0] va, input logic signed [DW-1:0] vb);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        ma[i][j] = va;
        mb[i][j] = vb;
      end
  endtask

  task automatic main_seq;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", res_valid_o, 0);
    check("R1", done_o, 0);
    check("R1", res_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", res_valid_o, 0);
    check("R1", done_o, 0);
    check("R1", res_o, 0);

    for (int r = 0; r < 6; r++) begin
      fill_rand(1'b0);
      run(1'b0, "R2");
    end
    fill_rand(1'b0);
    run(1'b1, "R7");          // R7 starts mid-run ignored
    fill_rand(1'b1);
    run(1'b0, "R2");          // all-negative
    fill_const(-8'sd128, -8'sd128);
    run(1'b0, "R8");
    fill_const(8'sd127, 8'sd127);
    run(1'b0, "R8");
    fill_const(-8'sd128, 8'sd127);
    run(1'b0, "R8");
    fill_const(8'sd0, 8'sd0);
    run(1'b0, "R9");          // R9 nothing left over from previous run
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        ma[i][j] = (i == j) ? 8'sd1 : 8'sd0;
        mb[i][j] = DW'(i * N + j - 7);
      end
    run(1'b0, "R4");          // identity exposes row/column placement
  endtask

  initial begin
    fork
      main_seq();
      begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule